// File: doc/BRIEF.md
# Chip-Select Read Timing Sequencer

This block produces the strobe sequence for a single read on an asynchronous external memory bank. A one-tick start request begins the access. The sequencer then drives the address-latch strobe, the address-valid window, the chip select and the read strobe, and it pulses done at the end. The block runs on a clock at twice the bus rate. One tick of that clock is half a bus cycle, so chip-select edges can fall on half-cycle boundaries.

The shape of the access comes from a set of per-bank option inputs. These are a relaxed-timing flag, an extended-hold flag, an extended-setup flag, a 2-bit setup code, a wait-state count and a latch length in bus cycles. The options are sampled only when a request is accepted. An access runs in four phases, in this order:

1. Latch: the address-latch strobe is high.
2. Setup: the address is valid and the chip select is not yet asserted.
3. Access: the chip select and the read strobe are high.
4. Hold: the chip select is released and the address is still valid.

All outputs are active high and registered. The bench's tick index 0 is the first tick after the clock edge that accepts start.

Top module: `cs_read_sequencer`

## Requirements
- R1: After reset, every output is low and the sequencer is idle.
- R2: The latch strobe rises in tick 0 and stays high for 2*len ticks. A latch length input of 0 is treated as 1. The address-valid output rises in the tick after the latch strobe falls.
- R3: With setup code 00 or 01, the chip select rises in the same tick as address-valid, whatever the other flags are.
- R4: With extended setup off and setup code 10 or 11, the chip select rises 1 tick after address-valid. In relaxed timing it rises 3 ticks after.
- R5: With extended setup on, code 10 delays the chip select by 2 ticks (4 when relaxed) and code 11 delays it by 4 ticks (6 when relaxed).
- R6: The time from the chip select falling to address-valid falling is 2 ticks normally, 4 with extended hold, 10 in relaxed timing, and 18 with both relaxed timing and extended hold.
- R7: In normal timing, with a latch length of 1, the access lasts 4+SCY bus cycles. Extended hold adds 1 cycle. Extended setup together with code 11 adds 1 more cycle. One bus cycle is 2 ticks.
- R8: In relaxed timing, with a latch length of 1, the access lasts 8+2*SCY cycles. Extended hold adds 4 cycles. A setup code of 10 or 11 adds 1 cycle. Extended setup with code 11 adds 1 further cycle.
- R9: Each latch cycle beyond the first lengthens the whole access by exactly one bus cycle.
- R10: The read strobe is high in exactly the ticks in which the chip select is high.
- R11: Done is high for exactly one tick, and that tick is the last tick of address-valid.
- R12: A start pulse during an access is ignored. Option inputs that change during an access are also ignored. The running access keeps its shape, and no second access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a read access; accepted only when idle |
| relax_i | input | 1 | Relaxed-timing flag |
| hold_ext_i | input | 1 | Extended-hold flag |
| setup_ext_i | input | 1 | Extended-setup flag |
| setup_code_i | input | 2 | Chip-select setup code |
| wait_cnt_i | input | SCY_W | Wait-state count SCY |
| latch_len_i | input | ALE_W | Latch strobe length in bus cycles (0 acts as 1) |
| ale_o | output | 1 | Address-latch strobe |
| addr_oe_o | output | 1 | Address-valid window |
| cs_o | output | 1 | Chip select |
| rd_o | output | 1 | Read strobe |
| done_o | output | 1 | One-tick end-of-access pulse |

## Verification
A wrong phase duration or a captured option that has been corrupted shows up at the ports within one access. The result is a chip-select edge that is shifted against address-valid, or a done tick that lands early or late. A wrong state transition, such as skipping the setup phase or re-entering the latch phase, shows up as an extra or missing latch strobe. That appears no later than the tick after done. Each access is therefore recorded tick by tick, and its edge positions are compared against the counts that the bench computes from the option flags.

// File: rtl/cs_read_seq_pkg.sv
package cs_read_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LATCH  = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACCESS = 3'd3,
    ST_HOLD   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/cs_read_timing_calc.sv
// Converts option flags into phase lengths counted in half-bus-cycle ticks.
module cs_read_timing_calc #(
  parameter int SCY_W  = 4,
  parameter int ALE_W  = 2,
  parameter int TICK_W = SCY_W + 4
) (
  input  logic              relax_i,
  input  logic              hold_ext_i,
  input  logic              setup_ext_i,
  input  logic [1:0]        setup_code_i,
  input  logic [SCY_W-1:0]  wait_cnt_i,
  input  logic [ALE_W-1:0]  latch_len_i,
  output logic [TICK_W-1:0] latch_ticks_o,
  output logic [TICK_W-1:0] setup_ticks_o,
  output logic [TICK_W-1:0] access_ticks_o,
  output logic [TICK_W-1:0] hold_ticks_o
);
  logic [TICK_W-1:0] scy_t, base_cyc, addr_ticks, len_t;
  logic              late_cs;

  always_comb begin
    scy_t   = TICK_W'(wait_cnt_i);
    late_cs = setup_ext_i && (setup_code_i == 2'b11);

    // bus cycles covered with a one-cycle latch strobe
    if (relax_i) begin
      base_cyc = TICK_W'(8) + (scy_t << 1) + (hold_ext_i ? TICK_W'(4) : TICK_W'(0))
               + TICK_W'(setup_code_i[1]) + TICK_W'(late_cs);
      hold_ticks_o = hold_ext_i ? TICK_W'(18) : TICK_W'(10);
    end else begin
      base_cyc = TICK_W'(4) + scy_t + TICK_W'(hold_ext_i) + TICK_W'(late_cs);
      hold_ticks_o = hold_ext_i ? TICK_W'(4) : TICK_W'(2);
    end

    if (!setup_code_i[1])
      setup_ticks_o = '0;
    else if (!setup_ext_i)
      setup_ticks_o = relax_i ? TICK_W'(3) : TICK_W'(1);
    else
      setup_ticks_o = (setup_code_i[0] ? TICK_W'(4) : TICK_W'(2))
                    + (relax_i ? TICK_W'(2) : TICK_W'(0));

    len_t          = (latch_len_i == '0) ? TICK_W'(1) : TICK_W'(latch_len_i);
    latch_ticks_o  = len_t << 1;
    // one latch cycle is part of base_cyc; the rest is the address window
    addr_ticks     = (base_cyc << 1) - TICK_W'(2);
    access_ticks_o = addr_ticks - setup_ticks_o - hold_ticks_o;
  end
endmodule

// File: rtl/cs_read_phase_fsm.sv
// Phase sequencer: one down-counter walks latch, setup, access and hold.
module cs_read_phase_fsm
  import cs_read_seq_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TICK_W-1:0] latch_ticks_i,
  input  logic [TICK_W-1:0] setup_ticks_i,
  input  logic [TICK_W-1:0] access_ticks_i,
  input  logic [TICK_W-1:0] hold_ticks_i,
  output logic              ale_o,
  output logic              addr_oe_o,
  output logic              cs_o,
  output logic              rd_o,
  output logic              done_o
);
  seq_state_t        st_q, nxt_st;
  logic [TICK_W-1:0] cnt_q, nxt_cnt;
  logic [TICK_W-1:0] setup_q, access_q, hold_q;
  logic              take;

  always_comb begin
    nxt_st  = st_q;
    nxt_cnt = cnt_q;
    take    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        nxt_st  = ST_LATCH;
        nxt_cnt = latch_ticks_i - TICK_W'(1);
        take    = 1'b1;
      end
      ST_LATCH: if (cnt_q == '0) begin
        if (setup_q == '0) begin
          nxt_st  = ST_ACCESS;
          nxt_cnt = access_q - TICK_W'(1);
        end else begin
          nxt_st  = ST_SETUP;
          nxt_cnt = setup_q - TICK_W'(1);
        end
      end else nxt_cnt = cnt_q - TICK_W'(1);
      ST_SETUP: if (cnt_q == '0) begin
        nxt_st  = ST_ACCESS;
        nxt_cnt = access_q - TICK_W'(1);
      end else nxt_cnt = cnt_q - TICK_W'(1);
      ST_ACCESS: if (cnt_q == '0) begin
        nxt_st  = ST_HOLD;
        nxt_cnt = hold_q - TICK_W'(1);
      end else nxt_cnt = cnt_q - TICK_W'(1);
      ST_HOLD: if (cnt_q == '0) nxt_st = ST_IDLE;
        else nxt_cnt = cnt_q - TICK_W'(1);
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      setup_q   <= '0;
      access_q  <= '0;
      hold_q    <= '0;
      ale_o     <= 1'b0;
      addr_oe_o <= 1'b0;
      cs_o      <= 1'b0;
      rd_o      <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      st_q  <= nxt_st;
      cnt_q <= nxt_cnt;
      if (take) begin
        setup_q  <= setup_ticks_i;
        access_q <= access_ticks_i;
        hold_q   <= hold_ticks_i;
      end
      ale_o     <= (nxt_st == ST_LATCH);
      addr_oe_o <= (nxt_st == ST_SETUP) || (nxt_st == ST_ACCESS) || (nxt_st == ST_HOLD);
      cs_o      <= (nxt_st == ST_ACCESS);
      rd_o      <= (nxt_st == ST_ACCESS);
      done_o    <= (nxt_st == ST_HOLD) && (nxt_cnt == '0);
    end
  end

  // R3: chip select only inside the address window
  p_cs_in_addr_r3: assert property (@(posedge clk) disable iff (rst)
    cs_o |-> addr_oe_o);
  // R6: address still valid when chip select drops
  p_hold_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_o) |-> addr_oe_o);
  // R6: hold counter never exceeds the captured hold length
  p_hold_cnt_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> (cnt_q < hold_q));
  // R11: done lasts one tick and closes the address window
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_ends_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!addr_oe_o && !cs_o));
  // R12: an access only begins from idle
  p_accept_idle_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(ale_o) |-> ($past(st_q) == ST_IDLE));
  // R2: latch strobe spans at least one full bus cycle
  p_latch_min_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_o) |-> $past(ale_o, 2));
endmodule

// File: rtl/cs_read_sequencer.sv
module cs_read_sequencer #(
  parameter int SCY_W = 4,
  parameter int ALE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             relax_i,
  input  logic             hold_ext_i,
  input  logic             setup_ext_i,
  input  logic [1:0]       setup_code_i,
  input  logic [SCY_W-1:0] wait_cnt_i,
  input  logic [ALE_W-1:0] latch_len_i,
  output logic             ale_o,
  output logic             addr_oe_o,
  output logic             cs_o,
  output logic             rd_o,
  output logic             done_o
);
  localparam int TICK_W = ((SCY_W + 4) > (ALE_W + 2)) ? (SCY_W + 4) : (ALE_W + 2);

  logic [TICK_W-1:0] latch_t, setup_t, access_t, hold_t;

  cs_read_timing_calc #(.SCY_W(SCY_W), .ALE_W(ALE_W), .TICK_W(TICK_W)) u_calc (
    .relax_i        (relax_i),
    .hold_ext_i     (hold_ext_i),
    .setup_ext_i    (setup_ext_i),
    .setup_code_i   (setup_code_i),
    .wait_cnt_i     (wait_cnt_i),
    .latch_len_i    (latch_len_i),
    .latch_ticks_o  (latch_t),
    .setup_ticks_o  (setup_t),
    .access_ticks_o (access_t),
    .hold_ticks_o   (hold_t)
  );

  cs_read_phase_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .latch_ticks_i  (latch_t),
    .setup_ticks_i  (setup_t),
    .access_ticks_i (access_t),
    .hold_ticks_i   (hold_t),
    .ale_o          (ale_o),
    .addr_oe_o      (addr_oe_o),
    .cs_o           (cs_o),
    .rd_o           (rd_o),
    .done_o         (done_o)
  );
endmodule

// File: tb/test_cs_read_sequencer.sv
`timescale 1ns/1ps
module test_cs_read_sequencer;
  localparam int SCY_W  = 4;
  localparam int ALE_W  = 2;
  localparam int SCY_MX = (1 << SCY_W) - 1;
  localparam int WIN    = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, relax_i = 1'b0, hold_ext_i = 1'b0, setup_ext_i = 1'b0;
  logic [1:0] setup_code_i = 2'b00;
  logic [SCY_W-1:0] wait_cnt_i = '0;
  logic [ALE_W-1:0] latch_len_i = '0;
  logic ale_o, addr_oe_o, cs_o, rd_o, done_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  cs_read_sequencer #(.SCY_W(SCY_W), .ALE_W(ALE_W)) i_cs_read_sequencer (
    .clk(clk), .rst(rst), .start_i(start_i), .relax_i(relax_i),
    .hold_ext_i(hold_ext_i), .setup_ext_i(setup_ext_i),
    .setup_code_i(setup_code_i), .wait_cnt_i(wait_cnt_i),
    .latch_len_i(latch_len_i), .ale_o(ale_o), .addr_oe_o(addr_oe_o),
    .cs_o(cs_o), .rd_o(rd_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_setup(bit rlx, bit xacs, logic [1:0] code);
    if (code[1] == 1'b0) return 0;
    if (!xacs) return rlx ? 3 : 1;
    return ((code == 2'b10) ? 2 : 4) + (rlx ? 2 : 0);
  endfunction

  function automatic int exp_hold(bit rlx, bit ehtr);
    if (rlx) return ehtr ? 18 : 10;
    return ehtr ? 4 : 2;
  endfunction

  function automatic int exp_cycles(bit rlx, bit ehtr, bit xacs, logic [1:0] code,
                                    int scy, int len);
    int c;
    bit both11 = xacs && (code == 2'b11);
    if (rlx) c = 8 + 2*scy + (ehtr ? 4 : 0) + (code[1] ? 1 : 0) + (both11 ? 1 : 0);
    else     c = 4 + scy + (ehtr ? 1 : 0) + (both11 ? 1 : 0);
    return c + len - 1;
  endfunction

  task automatic run_access(input bit rlx, input bit ehtr, input bit xacs,
                            input logic [1:0] code, input int scy, input int len_in,
                            input bit poke);
    bit ale_s[WIN], adr_s[WIN], cs_s[WIN], rd_s[WIN], dn_s[WIN];
    int len, L, S, H, T, span;
    int ale_cnt, ale_first, ale_last, adr_first, adr_last, adr_cnt;
    int cs_first, cs_last, rd_bad, dn_cnt, dn_idx;
    string setup_tag, total_tag;
    len = (len_in == 0) ? 1 : len_in;
    L = 2*len; S = exp_setup(rlx, xacs, code); H = exp_hold(rlx, ehtr);
    T = 2*exp_cycles(rlx, ehtr, xacs, code, scy, len);
    span = T + 6;
    @(negedge clk);
    relax_i = rlx; hold_ext_i = ehtr; setup_ext_i = xacs; setup_code_i = code;
    wait_cnt_i = SCY_W'(scy); latch_len_i = ALE_W'(len_in); start_i = 1'b1;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (i == 0) start_i = 1'b0;
      ale_s[i] = ale_o; adr_s[i] = addr_oe_o; cs_s[i] = cs_o;
      rd_s[i] = rd_o; dn_s[i] = done_o;
      if (poke && i == 4) begin
        start_i = 1'b1; relax_i = ~rlx; hold_ext_i = ~ehtr;
        setup_code_i = ~code; wait_cnt_i = ~SCY_W'(scy); latch_len_i = '1;
      end
      if (poke && i == 5) start_i = 1'b0;
    end
    ale_cnt = 0; ale_first = -1; ale_last = -1; adr_first = -1; adr_last = -1; adr_cnt = 0;
    cs_first = -1; cs_last = -1; rd_bad = 0; dn_cnt = 0; dn_idx = -1;
    for (int i = 0; i < span; i++) begin
      if (ale_s[i]) begin ale_cnt++; if (ale_first < 0) ale_first = i; ale_last = i; end
      if (adr_s[i]) begin adr_cnt++; if (adr_first < 0) adr_first = i; adr_last = i; end
      if (cs_s[i]) begin if (cs_first < 0) cs_first = i; cs_last = i; end
      if (rd_s[i] != cs_s[i]) rd_bad++;
      if (dn_s[i]) begin dn_cnt++; dn_idx = i; end
    end
    setup_tag = (code[1] == 1'b0) ? "R3 setup" : (xacs ? "R5 setup" : "R4 setup");
    total_tag = (len > 1) ? "R9 total" : (rlx ? "R8 total" : "R7 total");
    chk(ale_first == 0 && ale_last == L-1 && ale_cnt == L, "R2 latch length", ale_cnt, L);
    chk(adr_first == L, "R2 address start", adr_first, L);
    chk(cs_first - adr_first == S, setup_tag, cs_first - adr_first, S);
    chk(adr_last - cs_last == H, "R6 hold", adr_last - cs_last, H);
    chk(adr_last + 1 == T, total_tag, adr_last + 1, T);
    chk(rd_bad == 0, "R10 read strobe", rd_bad, 0);
    chk(dn_cnt == 1 && dn_idx == adr_last, "R11 done", dn_idx, adr_last);
    if (poke)
      chk(adr_cnt == T - L && ale_cnt == L, "R12 busy start ignored", adr_cnt, T - L);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!ale_o && !addr_oe_o && !cs_o && !rd_o && !done_o, "R1 reset outputs",
        {ale_o, addr_oe_o, cs_o, rd_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ale_o && !addr_oe_o && !cs_o && !done_o, "R1 idle after reset",
        {ale_o, addr_oe_o, cs_o, rd_o, done_o}, 0);

    // every flag and code combination at both SCY extremes
    for (int k = 0; k < 32; k++) begin
      run_access(k[4], k[3], k[2], k[1:0], 0, 1, 1'b0);
      run_access(k[4], k[3], k[2], k[1:0], SCY_MX, 1, 1'b0);
    end
    // latch length corners, including 0 treated as 1
    run_access(1'b0, 1'b0, 1'b0, 2'b00, 0, 0, 1'b0);
    run_access(1'b1, 1'b1, 1'b1, 2'b11, SCY_MX, 3, 1'b0);
    run_access(1'b0, 1'b1, 1'b1, 2'b10, 2, 2, 1'b0);
    // busy-time start and option changes
    run_access(1'b0, 1'b0, 1'b0, 2'b00, 0, 1, 1'b1);
    run_access(1'b1, 1'b1, 1'b0, 2'b10, 5, 2, 1'b1);
    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r = $urandom;
      run_access(r[0], r[1], r[2], r[4:3], int'(r[11:8]) % (SCY_MX + 1),
                 int'(r[13:12]), r[14]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule